// File: doc/BRIEF.md
# Configurable Four-Input Lookup Cell

This block is a small lookup cell with a power-of-two array of storage bits (sixteen by default) and an optional output register. A parameter fixes one of four behaviours for the same storage. It can act as a read-only function generator, so any function of the address inputs is available. It can act as a single-port RAM, or as a RAM with a second independent read port. It can also act as an addressable shift register.

All reads are combinational. Writes, shifts and the output register act on the rising clock edge. The output register samples the primary read output. It has a clock enable, which a parameter can tie permanently on, and an asynchronous clear. An active-low global reset reloads the storage from an initial-value parameter and clears the register.

Top module: `lut_cell`

## Requirements
- R1: With MODE=0 (function generator), `q` equals bit `addr` of the INIT parameter, combinationally, for every address.
- R2: With MODE=0, `we` and `din` have no effect: after clock edges with `we` high, `q` still equals INIT bit `addr`.
- R3: With MODE=1 (single-port RAM), a rising edge with `we`=1 stores `din` at location `addr`. With `we`=0 the contents hold. `q` is the stored bit at `addr`.
- R4: With MODE=2 (dual-port RAM), writes and `q` behave as in R3, and `dq` is the stored bit at `raddr`, independent of `addr`.
- R5: In every mode other than MODE=2, `dq` is 0.
- R6: With MODE=3 (shift register), a rising edge with `we`=1 moves `din` into stage 0 and moves every stage k into stage k+1. With `we`=0 the stages hold. `q` is stage `addr`.
- R7: With CE_USED=1, `q_reg` takes the value `q` had just before a rising edge when `ce`=1, and keeps its value when `ce`=0.
- R8: `clr`=1 forces `q_reg` to 0 at once, without a clock edge and whatever `ce` is, and keeps it 0 while held.
- R9: With CE_USED=0, `q_reg` loads `q` on every rising edge whatever `ce` is.
- R10: `rst_n`=0 at once returns the storage to INIT and `q_reg` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for writes, shifts and the output register |
| rst_n | input | 1 | Asynchronous active-low global reset |
| addr | input | ADDR_W | Read address; also the write address |
| raddr | input | ADDR_W | Second read address (used in MODE=2) |
| din | input | 1 | Write or shift data bit |
| we | input | 1 | Write / shift enable |
| ce | input | 1 | Output register clock enable |
| clr | input | 1 | Asynchronous clear of the output register |
| q | output | 1 | Combinational read at `addr` |
| dq | output | 1 | Combinational read at `raddr` (MODE=2), else 0 |
| q_reg | output | 1 | Registered copy of `q` |

## Verification
`q` and `dq` follow their addresses with no delay. A write or shift first shows on them after the rising edge where `we` was high. `q_reg` shows the pre-edge value of `q` one edge later. `clr` and `rst_n` act without waiting for any edge. The bench drives all inputs on the falling edge and checks on the next falling edge. At the rising edge between the two, its models capture the register value from the old contents and only then apply the write. The clear and reset checks sample a few nanoseconds after the control is raised and before any rising edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

   typedef enum logic [1:0] {
      LUT_FUNC  = 2'd0,
      LUT_SPRAM = 2'd1,
      LUT_DPRAM = 2'd2,
      LUT_SHIFT = 2'd3
   } lut_mode_e;

endpackage

// File: rtl/lut_store.sv
module lut_store
   import lut_cell_pkg::*;
#(
   parameter int                      ADDR_W = 4,
   parameter int                      MODE   = 0,
   parameter logic [(1<<ADDR_W)-1:0]  INIT   = '0
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic                      din,
   input  logic                      we,
   output logic [(1<<ADDR_W)-1:0]    bits
);
   localparam int        DEPTH  = 1 << ADDR_W;
   localparam lut_mode_e MODE_E = lut_mode_e'(MODE[1:0]);

   logic [DEPTH-1:0] nxt;

   always_comb begin
      nxt = bits;
      case (MODE_E)
         LUT_SPRAM, LUT_DPRAM: if (we) nxt[waddr] = din;
         LUT_SHIFT:            if (we) nxt = {bits[DEPTH-2:0], din};
         default:              nxt = bits;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits <= INIT;
      else        bits <= nxt;
   end

   generate
      if (MODE == 1 || MODE == 2) begin : g_ram_chk
         // R3 / R4: a write lands at the address presented on that edge
         a_r3_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> bits[$past(waddr)] == $past(din));
      end
      if (MODE == 3) begin : g_shift_chk
         a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> (bits[0] == $past(din)) && (bits[DEPTH-1:1] == $past(bits[DEPTH-2:0])));
         a_r6_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(bits));
      end
   endgenerate
endmodule

// File: rtl/lut_read_mux.sv
module lut_read_mux #(
   parameter int ADDR_W = 4
)(
   input  logic [(1<<ADDR_W)-1:0] bits,
   input  logic [ADDR_W-1:0]      sel,
   output logic                   out
);
   assign out = bits[sel];
endmodule

// File: rtl/lut_out_ff.sv
module lut_out_ff #(
   parameter bit CE_USED = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ce,
   input  logic d,
   output logic q
);
   logic ce_eff;

   generate
      if (CE_USED) begin : g_ce
         assign ce_eff = ce;
      end else begin : g_no_ce
         assign ce_eff = ce | 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n or posedge clr) begin
      if (!rst_n)      q <= 1'b0;
      else if (clr)    q <= 1'b0;
      else if (ce_eff) q <= d;
   end

   // R7 (and R9 when the enable is tied on)
   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n || clr)
      ce_eff |=> q == $past(d));
   a_r7_ce_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
      !ce_eff |=> $stable(q));
   a_r8_async_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> q == 1'b0);
endmodule

// File: rtl/lut_cell.sv
module lut_cell
   import lut_cell_pkg::*;
#(
   parameter int                      ADDR_W  = 4,
   parameter int                      MODE    = 0,
   parameter bit                      CE_USED = 1'b1,
   parameter logic [(1<<ADDR_W)-1:0]  INIT    = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              din,
   input  logic              we,
   input  logic              ce,
   input  logic              clr,
   output logic              q,
   output logic              dq,
   output logic              q_reg
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
         $error("lut_cell: ADDR_W must lie in 1..8");
      end
      if (MODE < 0 || MODE > 3) begin : g_bad_mode
         $error("lut_cell: MODE must lie in 0..3");
      end
   endgenerate

   logic [DEPTH-1:0] bits;
   logic             rd_b;

   lut_store #(.ADDR_W(ADDR_W), .MODE(MODE), .INIT(INIT)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .waddr (addr),
      .din   (din),
      .we    (we),
      .bits  (bits)
   );

   lut_read_mux #(.ADDR_W(ADDR_W)) u_rd_a (
      .bits (bits),
      .sel  (addr),
      .out  (q)
   );

   lut_read_mux #(.ADDR_W(ADDR_W)) u_rd_b (
      .bits (bits),
      .sel  (raddr),
      .out  (rd_b)
   );

   generate
      if (MODE == 2) begin : g_dual
         assign dq = rd_b;
         // R4: a bit written at the second port's address appears on dq
         a_r4_dp_readthrough: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(we) && $past(addr) == $past(raddr) && $stable(raddr)) |-> dq == $past(din));
      end else begin : g_single
         assign dq = rd_b & 1'b0;
      end
      if (MODE == 0) begin : g_func_chk
         a_r1_func_read: assert property (@(posedge clk) disable iff (!rst_n)
            q == INIT[addr]);
      end
   endgenerate

   lut_out_ff #(.CE_USED(CE_USED)) u_oreg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .ce    (ce),
      .d     (q),
      .q     (q_reg)
   );
endmodule

// File: tb/lut_cell_bench.sv
`timescale 1ns/1ps
module lut_cell_bench;
   localparam int          AW     = 4;
   localparam logic [15:0] INIT_V = 16'hA5C3;
   localparam int          NC     = 5; // 0 func, 1 spram, 2 dpram, 3 shift, 4 func w/o enable

   logic clk = 1'b0, rst_n = 1'b0, din = 1'b0, we = 1'b0, ce = 1'b0, clr = 1'b0;
   logic [AW-1:0] addr = '0, raddr = '0;
   logic [NC-1:0] q_o, dq_o, qr_o;

   logic [15:0] mdl [NC];
   logic [NC-1:0] exp_r;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   generate
      for (genvar g = 0; g < NC; g++) begin : g_dut
         if (g == 2) begin : g_main
            lut_cell #(.ADDR_W(AW), .MODE(2), .CE_USED(1'b1), .INIT(INIT_V)) u_lut_cell (
               .clk(clk), .rst_n(rst_n), .addr(addr), .raddr(raddr), .din(din), .we(we),
               .ce(ce), .clr(clr), .q(q_o[g]), .dq(dq_o[g]), .q_reg(qr_o[g]));
         end else begin : g_var
            lut_cell #(.ADDR_W(AW), .MODE(g == 4 ? 0 : g), .CE_USED(g == 4 ? 1'b0 : 1'b1),
                       .INIT(INIT_V)) u_cell (
               .clk(clk), .rst_n(rst_n), .addr(addr), .raddr(raddr), .din(din), .we(we),
               .ce(ce), .clr(clr), .q(q_o[g]), .dq(dq_o[g]), .q_reg(qr_o[g]));
         end
      end
   endgenerate

   task automatic chk(string req, string what, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got=%b exp=%b t=%0t", req, what, got, exp, $time);
      end
   endtask

   function automatic string tag_q(int i, logic w);
      case (i)
         1: return "R3";
         2: return "R4";
         3: return "R6";
         default: return w ? "R2" : "R1";
      endcase
   endfunction

   task automatic reset_models();
      for (int i = 0; i < NC; i++) mdl[i] = INIT_V;
      exp_r = '0;
   endtask

   task automatic check_all(logic w);
      for (int i = 0; i < NC; i++) begin
         chk(tag_q(i, w), $sformatf("q[%0d]", i), q_o[i], mdl[i][addr]);
         chk(i == 4 ? "R9" : "R7", $sformatf("q_reg[%0d]", i), qr_o[i], exp_r[i]);
         chk(i == 2 ? "R4" : "R5", $sformatf("dq[%0d]", i), dq_o[i],
             i == 2 ? mdl[2][raddr] : 1'b0);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic cyc(logic [AW-1:0] a, logic [AW-1:0] ra, logic d, logic w, logic c);
      addr = a; raddr = ra; din = d; we = w; ce = c;
      @(posedge clk);
      for (int i = 0; i < NC; i++)
         if (!clr && (c || i == 4)) exp_r[i] = mdl[i][a];
      if (w) begin
         mdl[1][a] = d;
         mdl[2][a] = d;
         mdl[3]    = {mdl[3][14:0], d};
      end
      @(negedge clk);
      check_all(w);
   endtask

   initial begin
      reset_models();
      repeat (2) @(negedge clk);
      // R10: state held in reset
      for (int i = 0; i < NC; i++) begin
         chk("R10", "q_reg in reset", qr_o[i], 1'b0);
         chk("R10", "q in reset", q_o[i], INIT_V[0]);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int a = 0; a < 16; a++) cyc(AW'(a), AW'(15 - a), 1'b0, 1'b0, 1'b1);
      for (int a = 0; a < 16; a++) begin
         logic [3:0] av = 4'(a);
         cyc(av, av ^ 4'h5, av[0] ^ av[2] ^ 1'b1, 1'b1, 1'b1);
      end
      for (int a = 0; a < 16; a++) cyc(AW'(a), AW'(a), ~a[1], 1'b0, 1'b1);
      for (int a = 0; a < 16; a++) begin
         logic [3:0] av = 4'(15 - a);
         cyc(av, av, av[1] | av[3], 1'b1, 1'b1);
      end
      // R7 / R9: enable low
      for (int k = 0; k < 6; k++) cyc(AW'(k * 3), AW'(k), 1'b1, 1'b0, 1'b0);

      // R8: asynchronous clear before any rising edge
      #2 clr = 1'b1;
      #1;
      for (int i = 0; i < NC; i++) chk("R8", $sformatf("q_reg[%0d] clr", i), qr_o[i], 1'b0);
      exp_r = '0;
      @(negedge clk);
      cyc(4'd0, 4'd1, 1'b0, 1'b0, 1'b1);
      cyc(4'd1, 4'd2, 1'b0, 1'b0, 1'b1);
      clr = 1'b0;
      cyc(4'd0, 4'd3, 1'b0, 1'b0, 1'b1);
      cyc(4'd1, 4'd3, 1'b0, 1'b0, 1'b1);

      // R10: asynchronous reset after writes
      #2 rst_n = 1'b0;
      #1;
      reset_models();
      for (int i = 0; i < NC; i++) begin
         chk("R10", $sformatf("q_reg[%0d] rst", i), qr_o[i], 1'b0);
         chk("R10", $sformatf("q[%0d] rst", i), q_o[i], INIT_V[addr]);
      end
      @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < 16; a++) cyc(AW'(a), AW'(a ^ 9), 1'b1, 1'b0, 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got=running exp=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule